// File: doc/BRIEF.md
# Byte-wide timing register load port

This block is the host write path into a bank of nineteen 12-bit configuration registers. Index 0 is a status word and indices 1 to 18 hold timing values. A host drives an 8-bit bus, a select that marks the byte as an address or as data, a select that picks the low or the high part of a register, and a write strobe. The strobe is idle high. On its falling edge the block captures both selects. On its rising edge it acts on the bus byte. Because the strobe is asynchronous to the system clock, it is brought into the clock domain through a two-flop synchronizer, and both of its edges are detected there.

The port has two addressing modes. In manual mode the host sends an address cycle before the data cycles, and a per-strobe select steers each data byte to the low or high part of the register. In auto mode the host sends one start address. After that, data strobes alternate between low byte and high byte, and each high-byte write moves the address up by one. When the address has reached the last register (index 18), the next step returns it to the start address rather than to 0. All 19 registers can be programmed with 39 strobes in auto mode.

The control is a four-state machine. `ST_MAN_WAIT_FALL` and `ST_MAN_WAIT_RISE` are the manual states; `ST_AUTO_WAIT_FALL` and `ST_AUTO_WAIT_RISE` are the auto states.

- A detected falling edge moves each WAIT_FALL state to the WAIT_RISE state of the same mode.
- A detected rising edge moves each WAIT_RISE state back to a WAIT_FALL state:
  - an address cycle with the high select set enters `ST_AUTO_WAIT_FALL`;
  - an address cycle with the high select clear enters `ST_MAN_WAIT_FALL`;
  - a data cycle stays in the same mode.
- The asynchronous clear returns the machine to `ST_MAN_WAIT_FALL`.

Top module: `cfg_load_port`

## Requirements
- R1: While `clr` is high, asynchronously and without waiting for a clock edge, every register reads 0, except status bit 10 (register 0), which reads the value of parameter `CLKEN_DEFAULT`.
- R2: `sel_data` and `sel_high` are taken as they stand at the strobe's falling edge. Changing them while the strobe is low has no effect on the cycle.
- R3: A cycle with `sel_data`=0 and `sel_high`=0 loads the whole bus byte as the address for the data cycles that follow, and selects manual mode.
- R4: In manual mode, a data cycle (`sel_data`=1) with `sel_high`=0 writes bus bits 7:0 into register bits 7:0. With `sel_high`=1, it writes bus bits 3:0 into register bits 11:8. The other part of the register is left unchanged, and the address does not move.
- R5: A cycle with `sel_data`=0 and `sel_high`=1 loads the bus byte as both the start address and the current address, and enters auto mode. No register changes until the next data cycle.
- R6: In auto mode, the `sel_high` pin is ignored on data cycles. The first data cycle after the start address writes the low byte, the next writes the high byte, and so on alternately. Each high-byte write advances the address by one.
- R7: In auto mode, a high-byte write at address 18 sends the address back to the start address. For example, a start of 15 visits 15, 16, 17, 18, 15, 16 and so on.
- R8: In auto mode with a start address of 18 or above, the address never changes. A start of exactly 18 rewrites register 18 on every byte pair.
- R9: A data cycle whose address is above 18 changes no register.
- R10: Auto mode ends only at an address cycle with `sel_high`=0. The data cycles after it follow the manual rules.
- R11: A data write shows on `regs_flat` after the third rising clock edge that follows the strobe's rising edge. The falling edge of the strobe changes no register.
- R12: One auto-mode start at address 0 followed by 38 data strobes programs all 19 registers, a total of 39 strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| clr | input | 1 | Asynchronous clear, active high |
| cfg_strobe | input | 1 | Write strobe, idle high, asynchronous to `clk` |
| bus_byte | input | DATA_W | Address or data byte |
| sel_data | input | 1 | 0: the byte is an address; 1: the byte is data |
| sel_high | input | 1 | Low/high byte select; on an address cycle, 1 starts auto mode |
| regs_flat | output | NUM_REGS*REG_W | All registers; register i occupies bits [i*REG_W +: REG_W] |

## Verification
On every clock, the assertions check the following:
- the clear values;
- that registers change only in the cycle after a write strobe, and that the low and high write lanes are never active together;
- that writes above index 18 leave the bank untouched;
- that in auto mode the address stays between the start address and 18 and returns to the start address after 18;
- that a start address above 18 stays frozen.

Some behaviours need the bench scenarios to show them: the three-clock latency from the strobe edge, which select values are taken at the falling edge, the low/high alternation that ignores the pin, the wrap sequence starting from 15, the exit from auto mode, and the complete 39-strobe programming pass. The bench checks these against its reference model.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

    typedef enum logic [1:0] {
        ST_MAN_WAIT_FALL  = 2'd0,
        ST_MAN_WAIT_RISE  = 2'd1,
        ST_AUTO_WAIT_FALL = 2'd2,
        ST_AUTO_WAIT_RISE = 2'd3
    } port_state_t;

    typedef struct packed {
        logic is_data;
        logic is_high;
    } ctl_t;

endpackage

// File: rtl/load_strobe_sync.sv
module load_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic strobe_in,
    output logic fall_pulse,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Idle level of the strobe is high, so the chain clears to ones.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            chain_q <= '1;
            last_q  <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], strobe_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign fall_pulse = last_q & ~chain_q[STAGES-1];
    assign rise_pulse = ~last_q & chain_q[STAGES-1];

endmodule

// File: rtl/cfg_load_ctrl.sv
module cfg_load_ctrl
    import cfg_load_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ADDR_LAST = 18
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              fall_pulse,
    input  logic              rise_pulse,
    input  logic [ADDR_W-1:0] bus_byte,
    input  logic              sel_data,
    input  logic              sel_high,
    output logic              wr_lo,
    output logic              wr_hi,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              auto_on,
    output logic [ADDR_W-1:0] start_addr
);

    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(ADDR_LAST);

    port_state_t       state_q, state_d;
    ctl_t              ctl_q;
    logic [ADDR_W-1:0] addr_q, start_q, addr_step;
    logic              phase_hi_q;
    logic              take_ctl, act_cycle, addr_cycle, data_cycle, in_auto;

    // State register
    always_ff @(posedge clk or posedge clr) begin
        if (clr) state_q <= ST_MAN_WAIT_FALL;
        else     state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_MAN_WAIT_FALL:
                if (fall_pulse) state_d = ST_MAN_WAIT_RISE;
            ST_MAN_WAIT_RISE:
                if (rise_pulse)
                    state_d = (!ctl_q.is_data && ctl_q.is_high) ? ST_AUTO_WAIT_FALL
                                                                 : ST_MAN_WAIT_FALL;
            ST_AUTO_WAIT_FALL:
                if (fall_pulse) state_d = ST_AUTO_WAIT_RISE;
            ST_AUTO_WAIT_RISE:
                if (rise_pulse)
                    state_d = (!ctl_q.is_data && !ctl_q.is_high) ? ST_MAN_WAIT_FALL
                                                                  : ST_AUTO_WAIT_FALL;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        take_ctl  = 1'b0;
        act_cycle = 1'b0;
        in_auto   = 1'b0;
        unique case (state_q)
            ST_MAN_WAIT_FALL:  take_ctl = fall_pulse;
            ST_MAN_WAIT_RISE:  act_cycle = rise_pulse;
            ST_AUTO_WAIT_FALL: begin take_ctl = fall_pulse; in_auto = 1'b1; end
            ST_AUTO_WAIT_RISE: begin act_cycle = rise_pulse; in_auto = 1'b1; end
        endcase
        addr_cycle = act_cycle & ~ctl_q.is_data;
        data_cycle = act_cycle & ctl_q.is_data;
        wr_lo = data_cycle & (in_auto ? ~phase_hi_q : ~ctl_q.is_high);
        wr_hi = data_cycle & (in_auto ?  phase_hi_q :  ctl_q.is_high);
    end

    assign addr_step = (addr_q >= LAST_A) ? start_q : addr_q + ADDR_W'(1);

    // Control capture, address counter and byte phase
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            ctl_q      <= '0;
            addr_q     <= '0;
            start_q    <= '0;
            phase_hi_q <= 1'b0;
        end else begin
            if (take_ctl) begin
                ctl_q.is_data <= sel_data;
                ctl_q.is_high <= sel_high;
            end
            if (addr_cycle) begin
                addr_q     <= bus_byte;
                start_q    <= bus_byte;
                phase_hi_q <= 1'b0;
            end else if (data_cycle && in_auto) begin
                phase_hi_q <= ~phase_hi_q;
                if (phase_hi_q) addr_q <= addr_step;
            end
        end
    end

    assign wr_addr    = addr_q;
    assign auto_on    = in_auto;
    assign start_addr = start_q;

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
    parameter int NUM_REGS      = 19,
    parameter int REG_W         = 12,
    parameter int DATA_W        = 8,
    parameter int ADDR_W        = 8,
    parameter int CLKEN_BIT     = 10,
    parameter bit CLKEN_DEFAULT = 1'b0
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic                      wr_lo,
    input  logic                      wr_hi,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_byte,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    localparam int HI_W = REG_W - DATA_W;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [REG_W-1:0] RST_VAL =
            (g == 0 && CLKEN_DEFAULT) ? (REG_W'(1) << CLKEN_BIT) : '0;
        logic             hit;
        logic [REG_W-1:0] q;

        assign hit = (wr_addr == ADDR_W'(g));

        always_ff @(posedge clk or posedge clr) begin
            if (clr) begin
                q <= RST_VAL;
            end else if (hit) begin
                if (wr_lo) q[DATA_W-1:0]    <= wr_byte;
                if (wr_hi) q[REG_W-1:DATA_W] <= wr_byte[HI_W-1:0];
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = q;
    end

endmodule

// File: rtl/cfg_load_port.sv
module cfg_load_port #(
    parameter int NUM_REGS      = 19,
    parameter int REG_W         = 12,
    parameter int DATA_W        = 8,
    parameter int SYNC_STAGES   = 2,
    parameter int CLKEN_BIT     = 10,
    parameter bit CLKEN_DEFAULT = 1'b0
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic                      cfg_strobe,
    input  logic [DATA_W-1:0]         bus_byte,
    input  logic                      sel_data,
    input  logic                      sel_high,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);

    localparam int ADDR_LAST = NUM_REGS - 1;

    logic              fall_w, rise_w;
    logic              wr_lo_w, wr_hi_w, auto_on_w;
    logic [DATA_W-1:0] wr_addr_w, start_addr_w;

    load_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .clr        (clr),
        .strobe_in  (cfg_strobe),
        .fall_pulse (fall_w),
        .rise_pulse (rise_w)
    );

    cfg_load_ctrl #(.ADDR_W(DATA_W), .ADDR_LAST(ADDR_LAST)) u_ctrl (
        .clk        (clk),
        .clr        (clr),
        .fall_pulse (fall_w),
        .rise_pulse (rise_w),
        .bus_byte   (bus_byte),
        .sel_data   (sel_data),
        .sel_high   (sel_high),
        .wr_lo      (wr_lo_w),
        .wr_hi      (wr_hi_w),
        .wr_addr    (wr_addr_w),
        .auto_on    (auto_on_w),
        .start_addr (start_addr_w)
    );

    cfg_regfile #(
        .NUM_REGS      (NUM_REGS),
        .REG_W         (REG_W),
        .DATA_W        (DATA_W),
        .ADDR_W        (DATA_W),
        .CLKEN_BIT     (CLKEN_BIT),
        .CLKEN_DEFAULT (CLKEN_DEFAULT)
    ) u_regs (
        .clk       (clk),
        .clr       (clr),
        .wr_lo     (wr_lo_w),
        .wr_hi     (wr_hi_w),
        .wr_addr   (wr_addr_w),
        .wr_byte   (bus_byte),
        .regs_flat (regs_flat)
    );

endmodule

// File: rtl/cfg_load_port_chk.sv
module cfg_load_port_chk #(
    parameter int NUM_REGS      = 19,
    parameter int REG_W         = 12,
    parameter int ADDR_W        = 8,
    parameter int CLKEN_BIT     = 10,
    parameter bit CLKEN_DEFAULT = 1'b0
) (
    input logic                      clk,
    input logic                      clr,
    input logic [NUM_REGS*REG_W-1:0] regs_flat,
    input logic                      wr_lo,
    input logic                      wr_hi,
    input logic [ADDR_W-1:0]         wr_addr,
    input logic                      auto_on,
    input logic [ADDR_W-1:0]         start_addr
);

    localparam int                      TOT_W  = NUM_REGS * REG_W;
    localparam logic [ADDR_W-1:0]       LAST_A = ADDR_W'(NUM_REGS - 1);
    localparam logic [TOT_W-1:0]        RST_FLAT =
        CLKEN_DEFAULT ? (TOT_W'(1) << CLKEN_BIT) : '0;

    assert_clear_default_R1: assert property (@(posedge clk) disable iff (clr)
        $past(clr) |-> regs_flat == RST_FLAT);

    assert_quiet_hold_R11: assert property (@(posedge clk) disable iff (clr)
        !$past(wr_lo || wr_hi) |-> $stable(regs_flat));

    assert_single_lane_R4: assert property (@(posedge clk) disable iff (clr)
        $onehot0({wr_lo, wr_hi}));

    assert_ignore_far_R9: assert property (@(posedge clk) disable iff (clr)
        ((wr_lo || wr_hi) && wr_addr > LAST_A) |=> $stable(regs_flat));

    assert_auto_window_R7: assert property (@(posedge clk) disable iff (clr)
        (auto_on && start_addr <= LAST_A) |-> (wr_addr >= start_addr && wr_addr <= LAST_A));

    assert_wrap_target_R7: assert property (@(posedge clk) disable iff (clr)
        (wr_hi && auto_on && wr_addr == LAST_A) |=> wr_addr == $past(start_addr));

    assert_far_start_frozen_R8: assert property (@(posedge clk) disable iff (clr)
        (auto_on && start_addr > LAST_A) |-> wr_addr == start_addr);

endmodule

bind cfg_load_port cfg_load_port_chk #(
    .NUM_REGS      (NUM_REGS),
    .REG_W         (REG_W),
    .ADDR_W        (DATA_W),
    .CLKEN_BIT     (CLKEN_BIT),
    .CLKEN_DEFAULT (CLKEN_DEFAULT)
) u_chk (
    .clk        (clk),
    .clr        (clr),
    .regs_flat  (regs_flat),
    .wr_lo      (wr_lo_w),
    .wr_hi      (wr_hi_w),
    .wr_addr    (wr_addr_w),
    .auto_on    (auto_on_w),
    .start_addr (start_addr_w)
);

// File: tb/sim_cfg_load_port.sv
`timescale 1ns/1ps
module sim_cfg_load_port;

    logic         clk = 1'b0;
    logic         clr = 1'b1;
    logic         cfg_strobe = 1'b1;
    logic [7:0]   bus_byte = '0;
    logic         sel_data = 1'b0;
    logic         sel_high = 1'b0;
    logic [227:0] regs_u0;
    logic [227:0] regs_u1;

    int  checks = 0;
    int  failures = 0;
    bit  run_cmp = 1'b0;
    bit  done = 1'b0;
    int  strobes = 0;

    // reference model state
    logic [11:0] m_regs [19];
    int          m_addr, m_start;
    bit          m_auto, m_phase;

    always #2 clk = ~clk;

    cfg_load_port u0 (
        .clk(clk), .clr(clr), .cfg_strobe(cfg_strobe), .bus_byte(bus_byte),
        .sel_data(sel_data), .sel_high(sel_high), .regs_flat(regs_u0)
    );

    cfg_load_port #(.CLKEN_DEFAULT(1'b1)) u1 (
        .clk(clk), .clr(clr), .cfg_strobe(1'b1), .bus_byte(8'h00),
        .sel_data(1'b0), .sel_high(1'b0), .regs_flat(regs_u1)
    );

    function automatic logic [11:0] rd(input int i);
        return regs_u0[i*12 +: 12];
    endfunction

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 19; i++) m_regs[i] = 12'h000;
        m_addr = 0; m_start = 0; m_auto = 1'b0; m_phase = 1'b0;
    endtask

    task automatic model_apply(input logic ad, input logic hb, input logic [7:0] b);
        bit is_hi;
        if (!ad) begin
            m_addr = b; m_start = b; m_phase = 1'b0; m_auto = hb;
        end else begin
            is_hi = m_auto ? m_phase : hb;
            if (m_addr < 19) begin
                if (is_hi) m_regs[m_addr][11:8] = b[3:0];
                else       m_regs[m_addr][7:0]  = b;
            end
            if (m_auto) begin
                if (m_phase) m_addr = (m_addr >= 18) ? m_start : m_addr + 1;
                m_phase = !m_phase;
            end
        end
    endtask

    // one full strobe; late selects are applied while the strobe is low
    task automatic strobe2(input logic ad, input logic hb, input logic [7:0] b,
                           input logic ad_late, input logic hb_late);
        @(negedge clk);
        sel_data = ad; sel_high = hb; bus_byte = b;
        repeat (2) @(negedge clk);
        cfg_strobe = 1'b0;
        repeat (4) @(negedge clk);
        sel_data = ad_late; sel_high = hb_late;
        repeat (2) @(negedge clk);
        cfg_strobe = 1'b1;
        repeat (3) @(posedge clk);
        model_apply(ad, hb, b);
        strobes++;
        repeat (3) @(negedge clk);
    endtask

    task automatic strobe(input logic ad, input logic hb, input logic [7:0] b);
        strobe2(ad, hb, b, ad, hb);
    endtask

    task automatic do_clear();
        @(posedge clk); #1;
        clr = 1'b1;
        model_reset();
        repeat (2) @(posedge clk); #1;
        clr = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // per-cycle comparison against the reference model (R4 register bank)
    always @(negedge clk) begin
        if (run_cmp) begin
            checks++;
            for (int i = 0; i < 19; i++) begin
                if (rd(i) !== m_regs[i]) begin
                    failures++;
                    $display("FAIL R4 model compare reg%0d actual=%h expected=%h", i, rd(i), m_regs[i]);
                    break;
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        // R1 reset values for both clock-enable defaults
        chk("R1 status default 0", rd(0), 12'h000);
        chk("R1 status default 1", regs_u1[11:0], 12'h400);
        chk("R1 timing reg clear", rd(9), 12'h000);
        @(posedge clk); #1;
        clr = 1'b0;
        run_cmp = 1'b1;
        repeat (2) @(negedge clk);

        // R3 / R4 manual addressing
        strobe(1'b0, 1'b0, 8'd3);
        strobe(1'b1, 1'b0, 8'hA5);
        strobe(1'b1, 1'b1, 8'h7C);
        chk("R4 manual low+high", rd(3), 12'hCA5);
        strobe(1'b1, 1'b0, 8'h11);
        chk("R4 low write keeps high", rd(3), 12'hC11);
        chk("R3 neighbour untouched", rd(4), 12'h000);

        // R11 latency: fall changes nothing, write lands at 3rd edge after rise
        strobe(1'b0, 1'b0, 8'd7);
        @(negedge clk);
        sel_data = 1'b1; sel_high = 1'b0; bus_byte = 8'h3C;
        repeat (2) @(negedge clk);
        cfg_strobe = 1'b0;
        repeat (6) @(negedge clk);
        chk("R11 no change on fall", rd(7), 12'h000);
        cfg_strobe = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R11 not yet after 2 edges", rd(7), 12'h000);
        @(posedge clk);
        model_apply(1'b1, 1'b0, 8'h3C);
        @(negedge clk);
        chk("R11 written after 3rd edge", rd(7), 12'h03C);
        repeat (3) @(negedge clk);

        // R2 selects captured at the falling edge
        strobe(1'b0, 1'b0, 8'd3);
        strobe2(1'b1, 1'b0, 8'h5A, 1'b0, 1'b1);
        strobe(1'b1, 1'b1, 8'h0E);
        chk("R2 captured selects used", rd(3), 12'hE5A);

        // R5 / R6 / R7 auto mode from 15
        do_clear();
        strobe(1'b0, 1'b1, 8'd15);
        chk("R5 start changes nothing", rd(15), 12'h000);
        strobe(1'b1, 1'b1, 8'h20);          // pin says high, low is written
        chk("R6 low first", rd(15), 12'h020);
        strobe(1'b1, 1'b0, 8'h01);          // pin says low, high is written
        chk("R6 high second", rd(15), 12'h120);
        for (int k = 1; k < 8; k++) begin
            strobe(1'b1, 1'b1, 8'h20 + 8'(k));
            strobe(1'b1, 1'b0, 8'(k + 1));
        end
        chk("R7 wrap rewrote start reg", rd(15), 12'h524);
        chk("R7 last reg", rd(18), 12'h827);
        chk("R7 below start untouched", rd(14), 12'h000);

        // R8 start at 18 and above
        strobe(1'b0, 1'b1, 8'd18);
        strobe(1'b1, 1'b0, 8'h41);
        strobe(1'b1, 1'b0, 8'h01);
        strobe(1'b1, 1'b0, 8'h42);
        strobe(1'b1, 1'b0, 8'h02);
        chk("R8 start 18 stays", rd(18), 12'h242);
        strobe(1'b0, 1'b1, 8'd20);
        strobe(1'b1, 1'b0, 8'h99);
        strobe(1'b1, 1'b0, 8'h09);
        chk("R8 start 20 no write", rd(18), 12'h242);

        // R10 exit from auto mode
        strobe(1'b0, 1'b0, 8'd5);
        strobe(1'b1, 1'b0, 8'h66);
        strobe(1'b1, 1'b1, 8'h03);
        strobe(1'b1, 1'b0, 8'h77);
        chk("R10 manual again", rd(5), 12'h377);
        chk("R10 no increment", rd(6), 12'h000);

        // R9 manual write above 18
        strobe(1'b0, 1'b0, 8'd25);
        strobe(1'b1, 1'b0, 8'hFF);
        strobe(1'b1, 1'b1, 8'h0F);
        chk("R9 far write ignored reg18", rd(18), 12'h242);
        chk("R9 far write ignored reg0", rd(0), 12'h000);

        // R1 asynchronous clear mid-cycle
        @(posedge clk); #1;
        clr = 1'b1;
        model_reset();
        #1;
        chk("R1 async clear", rd(5), 12'h000);
        @(posedge clk); #1;
        clr = 1'b0;
        repeat (2) @(negedge clk);

        // R12 full program in 39 strobes
        strobes = 0;
        strobe(1'b0, 1'b1, 8'd0);
        for (int i = 0; i < 19; i++) begin
            strobe(1'b1, 1'b0, 8'(i * 7 + 3));
            strobe(1'b1, 1'b1, 8'(i));
        end
        checks++;
        if (strobes != 39) begin
            failures++;
            $display("FAIL R12 strobe count actual=%0d expected=39", strobes);
        end
        for (int i = 0; i < 19; i++)
            chk("R12 full program", rd(i), {4'(i), 8'(i * 7 + 3)});

        done = 1'b1;
        run_cmp = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule